// File: doc/BRIEF.md
# T1 Channelized Serial Port

This block terminates one receive line and one transmit line of a 1.544 Mbit/s T1 channelized link. Each line has its own bit clock, frame-sync input and serial data. A frame lasts 193 bit periods: a single framing bit followed by 24 time slots of eight bits each. On the receive side the sync pulse sets where the framing bit falls. The block then counts through the frame and delivers each completed time slot as a parallel byte, tagged with its slot number. The framing bit is delivered on its own strobe, and a sticky out-of-frame flag is set when a later sync disagrees with the running count.

On the transmit side the sync sets where the framing bit is launched. The framing bit value comes from a configuration input. The block asks for each slot byte one slot ahead of use, and a client answers with a write. A slot that gets no answer is sent as all ones.

Four configuration inputs choose the clock edge used for the receive sync, the receive data, the transmit sync and the transmit data launch. Each choice is independent of the others. Every signal sampled on a falling edge passes through a holding register into the rising-edge domain, so all counting logic runs on rising edges.

Top module: `t1_chan_port`

## Requirements
- R1: A frame is 193 bit periods long: one framing bit (position 0) followed by slots 0 to 23 of eight bits each. Within a slot, bit 0 is first on the line on both paths.
- R2: Each of rx_sync, rx_data and tx_sync is sampled on the rising clock edge when its configuration input is 0 and on the falling edge when it is 1. tx_data is launched on the rising edge when cfg_tx_data_fall is 0 and on the falling edge when it is 1. All four sync/data combinations give the same frame behaviour.
- R3: A receive sync that is high for a single sample makes the data sample of the very next bit period the framing bit. Its value appears on rx_fbit together with a one-cycle rx_fbit_vld.
- R4: When the eighth bit of a slot is received, rx_byte carries the slot with its first received bit in bit 0, rx_slot carries the slot index (0 to 23), and rx_byte_vld pulses for one cycle. Results for a data bit sampled at rising edge k, or at the falling edge half a period after k, appear just after rising edge k+2.
- R5: Once aligned, the receive count free-runs and wraps every 193 bits without any further sync. Each sync re-anchors the count.
- R6: rx_oof is set when a sync arrives after alignment at any bit other than the last bit of slot 23, and it stays set until reset. The first sync never sets it. The flag appears with the same latency as R4.
- R7: Before the first transmit sync, tx_data is 1 and tx_req stays low. Before the first receive sync, no receive strobe fires.
- R8: For a transmit sync sample taken in bit period k, the framing bit equal to cfg_tx_fbit is launched in bit period k+3, and the 192 slot bits follow.
- R9: In the rising-edge cycle where bit 0 of slot s starts, tx_req pulses with tx_req_slot = (s+1) mod 24. A byte written with tx_wr after that pulse and before the next slot starts is sent in the requested slot. If no byte is written, the slot carries 8'hFF.
- R10: While rst_n is low, all strobes and rx_oof are 0 and tx_data is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive bit clock |
| tx_clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_sync_fall | input | 1 | Sample rx_sync on the falling edge |
| cfg_rx_data_fall | input | 1 | Sample rx_data on the falling edge |
| cfg_tx_sync_fall | input | 1 | Sample tx_sync on the falling edge |
| cfg_tx_data_fall | input | 1 | Launch tx_data on the falling edge |
| cfg_tx_fbit | input | 1 | Framing bit value to transmit |
| rx_sync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Receive serial data |
| rx_byte | output | 8 | Assembled slot byte |
| rx_slot | output | 5 | Slot index of rx_byte |
| rx_byte_vld | output | 1 | One-cycle strobe for rx_byte |
| rx_fbit | output | 1 | Received framing bit |
| rx_fbit_vld | output | 1 | One-cycle strobe for rx_fbit |
| rx_oof | output | 1 | Sticky out-of-frame flag |
| tx_sync | input | 1 | Transmit frame sync |
| tx_data | output | 1 | Transmit serial data |
| tx_req | output | 1 | Request for the next slot byte |
| tx_req_slot | output | 5 | Slot index being requested |
| tx_wr | input | 1 | Write strobe answering a request |
| tx_wbyte | input | 8 | Byte for the requested slot |

## Verification
Receive results are due just after the second rising edge that follows the rising edge of the sample. For a falling-edge sample, that is the rising edge just before it. The bench model queues its expected receive events and compares them two cycles after each sample is driven. Transmit bits are due from the third bit period after the sync sample. The bench keeps its own anchor and compares the line in every period, a quarter period after the selected launch edge. tx_req is compared in the same cycle as the slot start it marks. Line inputs are driven a quarter period before whichever edge samples them, so each configuration sees the same sample sequence.

// File: rtl/t1p_pkg.sv
package t1p_pkg;
  localparam int unsigned DEF_SLOTS     = 24;
  localparam int unsigned DEF_SLOT_BITS = 8;

  // Frame length: one framing bit plus all slot bits
  function automatic int unsigned frame_len(int unsigned slots, int unsigned bits);
    return 1 + slots * bits;
  endfunction

  // Slot index of a nonzero frame position
  function automatic int unsigned pos_slot(int unsigned pos, int unsigned bits);
    return (pos - 1) / bits;
  endfunction

  // Bit index within its slot of a nonzero frame position
  function automatic int unsigned pos_bit(int unsigned pos, int unsigned bits);
    return (pos - 1) % bits;
  endfunction

  function automatic int unsigned next_pos(int unsigned pos, int unsigned flen);
    return (pos + 1 == flen) ? 0 : pos + 1;
  endfunction

  function automatic int unsigned next_slot(int unsigned slot, int unsigned slots);
    return (slot + 1 == slots) ? 0 : slot + 1;
  endfunction
endpackage

// File: rtl/t1p_edge_sampler.sv
module t1p_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic fall_sel,
  output logic q
);
  logic rise_a, rise_b, fall_a, fall_b;

  // Both variants reach the rising domain after the same number of rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_a <= 1'b0;
      rise_b <= 1'b0;
      fall_b <= 1'b0;
    end else begin
      rise_a <= din;
      rise_b <= rise_a;
      fall_b <= fall_a;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_a <= 1'b0;
    else        fall_a <= din;
  end

  assign q = fall_sel ? fall_b : rise_b;
endmodule

// File: rtl/t1p_rx_framer.sv
module t1p_rx_framer import t1p_pkg::*; #(
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_s,
  input  logic                     data_s,
  output logic [SLOT_BITS-1:0]     byte_o,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic                     byte_vld,
  output logic                     fbit_o,
  output logic                     fbit_vld,
  output logic                     oof
);
  localparam int unsigned FLEN   = frame_len(SLOTS, SLOT_BITS);
  localparam int unsigned CNT_W  = $clog2(FLEN);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic             locked;
  logic [CNT_W-1:0] pos;
  logic [SLOT_BITS-1:0] shreg;
  int unsigned      pos_i;

  assign pos_i = 32'(pos);

  // Named events for the checks below
  logic at_fbit, slot_done, at_boundary, misalign_ev;
  logic [SLOT_BITS-1:0] shifted;
  assign at_fbit     = locked && (pos == '0);
  assign slot_done   = locked && (pos != '0) && (pos_bit(pos_i, SLOT_BITS) == SLOT_BITS - 1);
  assign at_boundary = (pos_i == FLEN - 1);
  assign misalign_ev = sync_s && locked && !at_boundary;
  assign shifted     = {data_s, shreg[SLOT_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      pos      <= '0;
      shreg    <= '0;
      byte_o   <= '0;
      slot_o   <= '0;
      byte_vld <= 1'b0;
      fbit_o   <= 1'b0;
      fbit_vld <= 1'b0;
      oof      <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      fbit_vld <= 1'b0;
      shreg    <= shifted;
      if (at_fbit) begin
        fbit_o   <= data_s;
        fbit_vld <= 1'b1;
      end
      if (slot_done) begin
        byte_o   <= shifted;
        slot_o   <= SLOT_W'(pos_slot(pos_i, SLOT_BITS));
        byte_vld <= 1'b1;
      end
      if (misalign_ev) oof <= 1'b1;
      if (sync_s) begin
        pos    <= '0;
        locked <= 1'b1;
      end else if (locked) begin
        pos <= CNT_W'(next_pos(pos_i, FLEN));
      end
    end
  end

  AST_RX_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && fbit_vld)); // R1
  AST_RX_FBIT_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_s |-> ##2 fbit_vld); // R3
  AST_RX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (32'(slot_o) < SLOTS)); // R4
  AST_RX_OOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    oof |=> oof); // R6
  AST_RX_OOF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> $past(sync_s)); // R6
  AST_RX_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !sync_s) |=> !(byte_vld || fbit_vld)); // R7
endmodule

// File: rtl/t1p_tx_framer.sv
module t1p_tx_framer import t1p_pkg::*; #(
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_s,
  input  logic                     fbit_val,
  input  logic                     wr,
  input  logic [SLOT_BITS-1:0]     wbyte,
  output logic                     req,
  output logic [$clog2(SLOTS)-1:0] req_slot,
  output logic                     bit_o
);
  localparam int unsigned FLEN   = frame_len(SLOTS, SLOT_BITS);
  localparam int unsigned CNT_W  = $clog2(FLEN);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic                 locked, have;
  logic [CNT_W-1:0]     pos;
  logic [SLOT_BITS-1:0] shreg, nxt;
  int unsigned          pos_i;

  assign pos_i = 32'(pos);

  logic at_fbit, slot_start;
  logic [SLOT_BITS-1:0] load_val;
  assign at_fbit    = locked && (pos == '0);
  assign slot_start = locked && (pos != '0) && (pos_bit(pos_i, SLOT_BITS) == 0);
  assign load_val   = have ? nxt : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      pos      <= '0;
      shreg    <= '1;
      nxt      <= '0;
      have     <= 1'b0;
      req      <= 1'b0;
      req_slot <= '0;
      bit_o    <= 1'b1;
    end else begin
      req <= 1'b0;
      if (!locked) begin
        bit_o <= 1'b1;
      end else if (at_fbit) begin
        bit_o <= fbit_val;
      end else if (slot_start) begin
        bit_o    <= load_val[0];
        shreg    <= {1'b1, load_val[SLOT_BITS-1:1]};
        req      <= 1'b1;
        req_slot <= SLOT_W'(next_slot(pos_slot(pos_i, SLOT_BITS), SLOTS));
        have     <= 1'b0;
      end else begin
        bit_o <= shreg[0];
        shreg <= {1'b1, shreg[SLOT_BITS-1:1]};
      end
      // A write in the load cycle belongs to the slot requested next
      if (wr) begin
        nxt  <= wbyte;
        have <= 1'b1;
      end
      if (sync_s) begin
        pos    <= '0;
        locked <= 1'b1;
      end else if (locked) begin
        pos <= CNT_W'(next_pos(pos_i, FLEN));
      end
    end
  end

  AST_TX_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> bit_o); // R7
  AST_TX_NO_REQ_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !req); // R7
  AST_TX_FBIT_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    sync_s |-> ##2 (bit_o == $past(fbit_val))); // R8
  AST_TX_REQ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (32'(req_slot) < SLOTS)); // R9
endmodule

// File: rtl/t1_chan_port.sv
module t1_chan_port import t1p_pkg::*; #(
  parameter int unsigned SLOTS     = DEF_SLOTS,
  parameter int unsigned SLOT_BITS = DEF_SLOT_BITS
) (
  input  logic                     rx_clk,
  input  logic                     tx_clk,
  input  logic                     rst_n,
  input  logic                     cfg_rx_sync_fall,
  input  logic                     cfg_rx_data_fall,
  input  logic                     cfg_tx_sync_fall,
  input  logic                     cfg_tx_data_fall,
  input  logic                     cfg_tx_fbit,
  input  logic                     rx_sync,
  input  logic                     rx_data,
  output logic [SLOT_BITS-1:0]     rx_byte,
  output logic [$clog2(SLOTS)-1:0] rx_slot,
  output logic                     rx_byte_vld,
  output logic                     rx_fbit,
  output logic                     rx_fbit_vld,
  output logic                     rx_oof,
  input  logic                     tx_sync,
  output logic                     tx_data,
  output logic                     tx_req,
  output logic [$clog2(SLOTS)-1:0] tx_req_slot,
  input  logic                     tx_wr,
  input  logic [SLOT_BITS-1:0]     tx_wbyte
);
  localparam int unsigned RX_LINES = 2;

  logic [RX_LINES-1:0] rx_pins, rx_sel, rx_norm;
  assign rx_pins = {rx_data, rx_sync};
  assign rx_sel  = {cfg_rx_data_fall, cfg_rx_sync_fall};

  for (genvar i = 0; i < RX_LINES; i++) begin : g_rx_smp
    t1p_edge_sampler u_smp (
      .clk(rx_clk), .rst_n(rst_n), .din(rx_pins[i]),
      .fall_sel(rx_sel[i]), .q(rx_norm[i])
    );
  end

  logic tx_sync_n;
  t1p_edge_sampler u_tx_smp (
    .clk(tx_clk), .rst_n(rst_n), .din(tx_sync),
    .fall_sel(cfg_tx_sync_fall), .q(tx_sync_n)
  );

  t1p_rx_framer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(rx_clk), .rst_n(rst_n), .sync_s(rx_norm[0]), .data_s(rx_norm[1]),
    .byte_o(rx_byte), .slot_o(rx_slot), .byte_vld(rx_byte_vld),
    .fbit_o(rx_fbit), .fbit_vld(rx_fbit_vld), .oof(rx_oof)
  );

  logic tx_bit, tx_bit_neg;
  t1p_tx_framer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk(tx_clk), .rst_n(rst_n), .sync_s(tx_sync_n), .fbit_val(cfg_tx_fbit),
    .wr(tx_wr), .wbyte(tx_wbyte), .req(tx_req), .req_slot(tx_req_slot),
    .bit_o(tx_bit)
  );

  // Falling-edge launch: retime the rising-domain bit by half a period
  always_ff @(negedge tx_clk or negedge rst_n) begin
    if (!rst_n) tx_bit_neg <= 1'b1;
    else        tx_bit_neg <= tx_bit;
  end

  assign tx_data = cfg_tx_data_fall ? tx_bit_neg : tx_bit;
endmodule

// File: tb/tb_t1_chan_port.sv
`timescale 1ns/1ps
module tb_t1_chan_port;
  localparam int NCYC = 700;
  localparam int FLEN = 193; // R1: framing bit + 24 x 8

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic rst_n;
  logic cfg_rx_sync_fall, cfg_rx_data_fall, cfg_tx_sync_fall, cfg_tx_data_fall, cfg_tx_fbit;
  logic rx_sync, rx_data, tx_sync, tx_wr;
  logic [7:0] rx_byte, tx_wbyte;
  logic [4:0] rx_slot, tx_req_slot;
  logic rx_byte_vld, rx_fbit, rx_fbit_vld, rx_oof, tx_data, tx_req;

  t1_chan_port dut (
    .rx_clk(clk), .tx_clk(clk), .rst_n(rst_n),
    .cfg_rx_sync_fall(cfg_rx_sync_fall), .cfg_rx_data_fall(cfg_rx_data_fall),
    .cfg_tx_sync_fall(cfg_tx_sync_fall), .cfg_tx_data_fall(cfg_tx_data_fall),
    .cfg_tx_fbit(cfg_tx_fbit), .rx_sync(rx_sync), .rx_data(rx_data),
    .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_byte_vld(rx_byte_vld),
    .rx_fbit(rx_fbit), .rx_fbit_vld(rx_fbit_vld), .rx_oof(rx_oof),
    .tx_sync(tx_sync), .tx_data(tx_data), .tx_req(tx_req),
    .tx_req_slot(tx_req_slot), .tx_wr(tx_wr), .tx_wbyte(tx_wbyte)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_cfg(input int g);
    bit rs [0:1023];
    bit rd [0:1023];
    bit ts [0:1023];
    int tbl [0:23];
    bit [15:0] lf;
    int anchor, oof_m, tanchor, tpend, cur_byte, exp_line;
    string line_tag, cfg_tag;
    cfg_tag = $sformatf("cfg%0d R2", g);
    lf = 16'hACE1 + 16'(g * 7919);
    for (int k = 0; k < 1024; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rd[k] = lf[0];
      rs[k] = (k == 4) || (k == 197) || (k == 500); // 197 on boundary, 500 off it
      ts[k] = (k == 6) || (k == 199) || (k == 392);
    end
    for (int s = 0; s < 24; s++) tbl[s] = 255;
    anchor = -1; oof_m = 0; tanchor = -1; tpend = -1; cur_byte = 255; exp_line = 1;
    line_tag = "R7";

    rst_n = 1'b0;
    cfg_rx_sync_fall = g[1]; cfg_rx_data_fall = g[0];
    cfg_tx_sync_fall = g[1]; cfg_tx_data_fall = g[0];
    cfg_tx_fbit = (g == 1) || (g == 2);
    rx_sync = 0; rx_data = 0; tx_sync = 0; tx_wr = 0; tx_wbyte = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: state held in reset
    check("R10", "rx_byte_vld in reset", int'(rx_byte_vld), 0);
    check("R10", "rx_fbit_vld in reset", int'(rx_fbit_vld), 0);
    check("R10", "rx_oof in reset", int'(rx_oof), 0);
    check("R10", "tx_req in reset", int'(tx_req), 0);
    check("R10", "tx_data in reset", int'(tx_data), 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      #1;
      if (cfg_tx_data_fall && c > 0)
        check(line_tag, {"tx_data falling launch ", cfg_tag}, int'(tx_data), exp_line);
      if (!cfg_rx_sync_fall) rx_sync = rs[c];
      if (!cfg_rx_data_fall) rx_data = rd[c];
      if (!cfg_tx_sync_fall) tx_sync = ts[c];
      @(posedge clk);
      #1;
      if (cfg_rx_sync_fall) rx_sync = rs[c];
      if (cfg_rx_data_fall) rx_data = rd[c];
      if (cfg_tx_sync_fall) tx_sync = ts[c];
      tx_wr = 1'b0;

      // Receive model: sample k's results are due now
      begin
        int k, pos, e_vld, e_fv, e_byte, e_slot, e_fb;
        string btag;
        k = c - 2;
        e_vld = 0; e_fv = 0; e_byte = 0; e_slot = 0; e_fb = 0;
        if (k >= 0) begin
          if (anchor >= 0 && k >= anchor) begin
            pos = (k - anchor) % FLEN;
            if (pos == 0) begin
              e_fv = 1; e_fb = int'(rd[k]);
            end else if (pos % 8 == 0) begin
              e_vld = 1; e_slot = pos / 8 - 1;
              for (int i = 0; i < 8; i++) e_byte |= int'(rd[k - 7 + i]) << i;
            end
          end
          if (rs[k]) begin
            if (anchor >= 0 && ((k + 1 - anchor) % FLEN) != 0) oof_m = 1;
            anchor = k + 1;
          end
        end
        btag = (k >= 391 && k < 500) ? "R5" : "R4"; // R5: free-run frame
        check(anchor < 0 ? "R7" : btag, {"rx_byte_vld ", cfg_tag}, int'(rx_byte_vld), e_vld);
        if (e_vld) begin
          check(btag, {"rx_byte ", cfg_tag}, int'(rx_byte), e_byte);
          check(btag, {"rx_slot ", cfg_tag}, int'(rx_slot), e_slot);
        end
        check("R3", {"rx_fbit_vld ", cfg_tag}, int'(rx_fbit_vld), e_fv);
        if (e_fv) check("R3", {"rx_fbit ", cfg_tag}, int'(rx_fbit), e_fb);
        check("R6", {"rx_oof ", cfg_tag}, int'(rx_oof), oof_m);
      end

      // Transmit model: bit period c
      begin
        int pos, s, b, e_req, e_rs;
        if (tpend == c) tanchor = c;
        if (ts[c]) tpend = c + 3;
        e_req = 0; e_rs = 0;
        if (tanchor < 0) begin
          exp_line = 1; line_tag = "R7";
        end else begin
          pos = (c - tanchor) % FLEN;
          if (pos == 0) begin
            exp_line = int'(cfg_tx_fbit); line_tag = "R8";
          end else begin
            s = (pos - 1) / 8; b = (pos - 1) % 8;
            if (b == 0) begin
              cur_byte = tbl[s];
              e_req = 1; e_rs = (s + 1) % 24;
            end
            exp_line = (cur_byte >> b) & 1; line_tag = "R9";
          end
        end
        check(tanchor < 0 ? "R7" : "R9", {"tx_req ", cfg_tag}, int'(tx_req), e_req);
        if (e_req) check("R9", {"tx_req_slot ", cfg_tag}, int'(tx_req_slot), e_rs);
        if (!cfg_tx_data_fall)
          check(line_tag, {"tx_data rising launch ", cfg_tag}, int'(tx_data), exp_line);
        if (tx_req) begin
          int rq;
          rq = int'(tx_req_slot);
          if (rq % 5 == 3) begin
            tbl[rq] = 255; // unanswered: idle code
          end else begin
            tbl[rq] = (rq * 37 + c) & 255;
            tx_wr = 1'b1;
            tx_wbyte = 8'(tbl[rq]);
          end
        end
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    for (int g = 0; g < 4; g++) run_cfg(g);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule